// File: doc/BRIEF.md
# Serial EEPROM Read Sequencer

This block is a two-wire bus master that fetches bytes from a byte-addressed serial EEPROM. A command carries a mode, a 7-bit device code, a byte address and a byte count. The block generates the whole bus transaction by itself: the START condition, the select byte, an optional address-setting dummy write followed by a repeated START, the data bytes with the right acknowledge bit after each, and the final STOP. The bytes read come out on a valid/ready stream. While the stream is stalled, the bus clock is held low.

Three read forms are supported. The first reads at the device's current internal address. The second is a random read at a given address. The third is a random read that first polls the device's acknowledge, so that an internal write still in progress can finish. In every form, a count above one turns the access into a sequential read. The bus clock comes from the system clock through a programmable divider. Both lines are driven open-drain as pull-low enables, and the data line is sampled back.

Top module: `eerd_master`

## Requirements
- R1: After reset, and whenever idle, both bus lines are released (`scl_low_o` = 0, `sda_low_o` = 0), `cmd_ready_o` = 1 and `rd_valid_o` = 0.
- R2: Every bus bit lasts four quarter periods of `div_i`+1 system clocks each. Every SCL high pulse inside a transfer therefore lasts exactly 2*(`div_i`+1) clocks. SDA changes while SCL is high only as part of a START or a STOP.
- R3: Mode 0 (current address) sends one START and the select byte {dev,1}, then reads from the device's current address.
- R4: Modes 1 to 3 (random) send {dev,0}, then the address byte, then a repeated START with no STOP before it, then {dev,1}. Both select bytes carry the same 7-bit device code.
- R5: A command delivers `cmd_len_i`+1 bytes in bus order. The master drives ACK (SDA low in the ninth clock) after every byte except the last, drives NACK after the last byte, and then sends exactly one STOP.
- R6: While `rd_valid_o`=1 and `rd_ready_i`=0, the data stays stable, valid stays high and SCL stays low.
- R7: Modes 2 and 3 (bit 1 set) poll the device. A NACK on {dev,0} is followed by a new START without a STOP and the select byte is sent again. The first ACK continues straight into the address byte.
- R8: If polling sees `poll_max_i`+1 NACKed select attempts in a row, the block sends a STOP and finishes with `tout_o`=1 and no data.
- R9: Any other NACK from the device (select byte in modes 0 and 1, address byte, second select byte) makes the block send a STOP and finish with `err_o`=1 and no data.
- R10: Each command produces exactly one `done_o` pulse, issued after the STOP with both lines released. `err_o` and `tout_o` hold their outcome until the next command is accepted, and they are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| div_i | input | DIV_W | quarter-bit period minus one, in system clocks |
| poll_max_i | input | RETRY_W | select retries allowed while polling |
| cmd_valid_i | input | 1 | command offered |
| cmd_ready_o | output | 1 | block idle, command accepted |
| cmd_mode_i | input | 2 | 0 current, 1 random, 2/3 random with polling |
| cmd_dev_i | input | 7 | device code for the select byte |
| cmd_addr_i | input | 8 | byte address for random modes |
| cmd_len_i | input | LEN_W | bytes to read minus one |
| rd_valid_o | output | 1 | read byte available |
| rd_ready_i | input | 1 | read byte taken |
| rd_data_o | output | 8 | read byte |
| done_o | output | 1 | one-cycle end-of-command pulse |
| err_o | output | 1 | last command aborted on NACK |
| tout_o | output | 1 | last command ran out of polls |
| scl_low_o | output | 1 | pull SCL low |
| sda_low_o | output | 1 | pull SDA low |
| sda_i | input | 1 | SDA line level |

## Verification
The bench attaches a bus-level EEPROM model. The model can stay busy for a set number of select attempts, reject the address byte, or answer to a different device code. This exercises polling that succeeds on its last allowed try, polling that runs out by exactly one attempt, and aborts at each byte position. A design that miscounts retries would report a timeout one attempt early or late. A design that slips a STOP into a random read would let the current address wander. A design that acknowledges the last byte would leave the device driving the bus. Read addresses cross the 0xFF wrap and the stream is stalled at random points. Any byte dropped, repeated or changed during a stall shows up against the expected contents.

// File: rtl/eerd_pkg.sv
package eerd_pkg;
  typedef enum logic [1:0] {BOP_START, BOP_STOP, BOP_WR, BOP_RD} bop_e;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_START, SQ_TX, SQ_RACK, SQ_RX, SQ_HOLD, SQ_MACK, SQ_STOP
  } sq_e;
  typedef enum logic [1:0] {BK_SELW, BK_ADDR, BK_SELR} bk_e;
endpackage

// File: rtl/eerd_tick.sv
module eerd_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  always_comb begin
    if (clr_i || cnt_q == '0) cnt_d = div_i;
    else                      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q == '0) && !clr_i;
endmodule

// File: rtl/eerd_bitphy.sv
module eerd_bitphy
  import eerd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic op_valid_i,
  input  bop_e op_i,
  input  logic op_bit_i,
  output logic clr_o,
  output logic op_done_o,
  output logic rx_bit_o,
  output bop_e op_o,
  output logic scl_low_o,
  output logic sda_low_o,
  input  logic sda_i
);
  logic       busy_q, busy_d;
  bop_e       op_q, op_d;
  logic       bit_q, bit_d;
  logic [1:0] ph_q, ph_d;
  logic       rx_q, rx_d;
  logic       scl_q, scl_d;
  logic       sda_q, sda_d;
  logic       accept;

  assign accept    = op_valid_i && !busy_q;
  assign clr_o     = accept;
  assign op_done_o = busy_q && tick_i && (ph_q == 2'd3);

  always_comb begin
    busy_d = busy_q;
    op_d   = op_q;
    bit_d  = bit_q;
    ph_d   = ph_q;
    rx_d   = rx_q;
    if (accept) begin
      busy_d = 1'b1;
      op_d   = op_i;
      bit_d  = op_bit_i;
      ph_d   = 2'd0;
    end else if (busy_q && tick_i) begin
      ph_d = ph_q + 2'd1;
      if (ph_q == 2'd3) busy_d = 1'b0;
      if (ph_q == 2'd2) rx_d = sda_i;
    end
  end

  // line levels (1 = released) per operation and quarter
  always_comb begin
    scl_d = scl_q;
    sda_d = sda_q;
    if (busy_q) begin
      unique case (op_q)
        BOP_START: begin
          scl_d = (ph_q == 2'd1) || (ph_q == 2'd2);
          sda_d = (ph_q == 2'd0) || (ph_q == 2'd1);
        end
        BOP_STOP: begin
          scl_d = (ph_q != 2'd0);
          sda_d = (ph_q == 2'd2) || (ph_q == 2'd3);
        end
        BOP_WR: begin
          scl_d = (ph_q == 2'd1) || (ph_q == 2'd2);
          sda_d = bit_q;
        end
        default: begin
          scl_d = (ph_q == 2'd1) || (ph_q == 2'd2);
          sda_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= BOP_STOP;
      bit_q  <= 1'b1;
      ph_q   <= 2'd0;
      rx_q   <= 1'b1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      busy_q <= busy_d;
      op_q   <= op_d;
      bit_q  <= bit_d;
      ph_q   <= ph_d;
      rx_q   <= rx_d;
      scl_q  <= scl_d;
      sda_q  <= sda_d;
    end
  end

  assign rx_bit_o  = rx_q;
  assign op_o      = op_q;
  assign scl_low_o = !scl_q;
  assign sda_low_o = !sda_q;
endmodule

// File: rtl/eerd_master.sv
module eerd_master
  import eerd_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int LEN_W   = 6,
  parameter int RETRY_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [RETRY_W-1:0] poll_max_i,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic [1:0]         cmd_mode_i,
  input  logic [6:0]         cmd_dev_i,
  input  logic [7:0]         cmd_addr_i,
  input  logic [LEN_W-1:0]   cmd_len_i,
  output logic               rd_valid_o,
  input  logic               rd_ready_i,
  output logic [7:0]         rd_data_o,
  output logic               done_o,
  output logic               err_o,
  output logic               tout_o,
  output logic               scl_low_o,
  output logic               sda_low_o,
  input  logic               sda_i
);
  localparam int BIT_W = 3;

  logic rst_meta_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  logic tick, clr, op_valid, op_bit, op_done, rx_bit;
  bop_e op, phy_op;

  eerd_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_q), .clr_i(clr), .div_i(div_i), .tick_o(tick)
  );

  eerd_bitphy u_phy (
    .clk(clk), .rst_n(rst_q), .tick_i(tick), .op_valid_i(op_valid),
    .op_i(op), .op_bit_i(op_bit), .clr_o(clr), .op_done_o(op_done),
    .rx_bit_o(rx_bit), .op_o(phy_op), .scl_low_o(scl_low_o),
    .sda_low_o(sda_low_o), .sda_i(sda_i)
  );

  sq_e                st_q, st_d;
  bk_e                kind_q, kind_d;
  logic               pend_q, pend_d;
  logic [7:0]         tx_q, tx_d;
  logic [7:0]         rxsh_q, rxsh_d;
  logic [BIT_W-1:0]   bcnt_q, bcnt_d;
  logic [LEN_W-1:0]   left_q, left_d;
  logic [RETRY_W-1:0] tries_q, tries_d;
  logic [6:0]         dev_q, dev_d;
  logic [7:0]         addr_q, addr_d;
  logic               poll_q, poll_d;
  logic               err_q, err_d;
  logic               tout_q, tout_d;
  logic               done_q, done_d;

  // bit operation requested from the line engine
  always_comb begin
    op     = BOP_RD;
    op_bit = 1'b1;
    unique case (st_q)
      SQ_START: op = BOP_START;
      SQ_STOP:  op = BOP_STOP;
      SQ_TX:    begin op = BOP_WR; op_bit = tx_q[7]; end
      SQ_MACK:  begin op = BOP_WR; op_bit = (left_q == '0); end
      default:  op = BOP_RD;
    endcase
    op_valid = !pend_q && (st_q != SQ_IDLE) && (st_q != SQ_HOLD);
  end

  always_comb begin
    st_d    = st_q;
    kind_d  = kind_q;
    tx_d    = tx_q;
    rxsh_d  = rxsh_q;
    bcnt_d  = bcnt_q;
    left_d  = left_q;
    tries_d = tries_q;
    dev_d   = dev_q;
    addr_d  = addr_q;
    poll_d  = poll_q;
    err_d   = err_q;
    tout_d  = tout_q;
    done_d  = 1'b0;
    pend_d  = pend_q;
    if (op_valid) pend_d = 1'b1;
    if (op_done)  pend_d = 1'b0;
    unique case (st_q)
      SQ_IDLE: if (cmd_valid_i) begin
        dev_d   = cmd_dev_i;
        addr_d  = cmd_addr_i;
        left_d  = cmd_len_i;
        poll_d  = cmd_mode_i[1];
        kind_d  = (cmd_mode_i == 2'd0) ? BK_SELR : BK_SELW;
        tries_d = '0;
        err_d   = 1'b0;
        tout_d  = 1'b0;
        st_d    = SQ_START;
      end
      SQ_START: if (op_done) begin
        tx_d   = {dev_q, (kind_q == BK_SELR)};
        bcnt_d = '1;
        st_d   = SQ_TX;
      end
      SQ_TX: if (op_done) begin
        tx_d = {tx_q[6:0], 1'b0};
        if (bcnt_q == '0) st_d = SQ_RACK;
        else              bcnt_d = bcnt_q - 1'b1;
      end
      SQ_RACK: if (op_done) begin
        if (!rx_bit) begin
          unique case (kind_q)
            BK_SELW: begin kind_d = BK_ADDR; tx_d = addr_q; bcnt_d = '1; st_d = SQ_TX; end
            BK_ADDR: begin kind_d = BK_SELR; st_d = SQ_START; end
            default: begin bcnt_d = '1; st_d = SQ_RX; end
          endcase
        end else if (kind_q == BK_SELW && poll_q) begin
          if (tries_q != poll_max_i) begin
            tries_d = tries_q + 1'b1;
            st_d    = SQ_START;
          end else begin
            tout_d = 1'b1;
            st_d   = SQ_STOP;
          end
        end else begin
          err_d = 1'b1;
          st_d  = SQ_STOP;
        end
      end
      SQ_RX: if (op_done) begin
        rxsh_d = {rxsh_q[6:0], rx_bit};
        if (bcnt_q == '0) st_d = SQ_HOLD;
        else              bcnt_d = bcnt_q - 1'b1;
      end
      SQ_HOLD: if (rd_ready_i) st_d = SQ_MACK;
      SQ_MACK: if (op_done) begin
        if (left_q == '0) st_d = SQ_STOP;
        else begin
          left_d = left_q - 1'b1;
          bcnt_d = '1;
          st_d   = SQ_RX;
        end
      end
      SQ_STOP: if (op_done) begin
        done_d = 1'b1;
        st_d   = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q    <= SQ_IDLE;
      kind_q  <= BK_SELW;
      pend_q  <= 1'b0;
      tx_q    <= '0;
      rxsh_q  <= '0;
      bcnt_q  <= '0;
      left_q  <= '0;
      tries_q <= '0;
      dev_q   <= '0;
      addr_q  <= '0;
      poll_q  <= 1'b0;
      err_q   <= 1'b0;
      tout_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      kind_q  <= kind_d;
      pend_q  <= pend_d;
      tx_q    <= tx_d;
      rxsh_q  <= rxsh_d;
      bcnt_q  <= bcnt_d;
      left_q  <= left_d;
      tries_q <= tries_d;
      dev_q   <= dev_d;
      addr_q  <= addr_d;
      poll_q  <= poll_d;
      err_q   <= err_d;
      tout_q  <= tout_d;
      done_q  <= done_d;
    end
  end

  assign cmd_ready_o = (st_q == SQ_IDLE);
  assign rd_valid_o  = (st_q == SQ_HOLD);
  assign rd_data_o   = rxsh_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign tout_o      = tout_q;
endmodule

// File: rtl/eerd_master_chk.sv
module eerd_master_chk
  import eerd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_low,
  input logic       sda_low,
  input bop_e       cur_op,
  input logic       cmd_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       done,
  input logic       err,
  input logic       tout
);
  assert_sda_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(scl_low) && !scl_low && (sda_low != $past(sda_low)))
      |-> ($past(cur_op) == BOP_START || $past(cur_op) == BOP_STOP));

  assert_hold_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_hold_scl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> scl_low);

  assert_done_bus_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!scl_low && !sda_low && cmd_ready));

  assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(err && tout));

  assert_no_data_on_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err || tout) |-> !rd_valid);
endmodule

bind eerd_master eerd_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_low(scl_low_o), .sda_low(sda_low_o),
  .cur_op(phy_op), .cmd_ready(cmd_ready_o), .rd_valid(rd_valid_o),
  .rd_ready(rd_ready_i), .rd_data(rd_data_o), .done(done_o),
  .err(err_o), .tout(tout_o)
);

// File: tb/tb_eerd_master.sv
`timescale 1ns/1ps
module tb_eerd_master;
  localparam int DIV_W = 8, LEN_W = 6, RETRY_W = 6;
  localparam logic [6:0] DEVID = 7'h50;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [DIV_W-1:0] div_i;
  logic [RETRY_W-1:0] poll_max_i;
  logic cmd_valid_i, cmd_ready_o;
  logic [1:0] cmd_mode_i;
  logic [6:0] cmd_dev_i;
  logic [7:0] cmd_addr_i;
  logic [LEN_W-1:0] cmd_len_i;
  logic rd_valid_o, rd_ready_i;
  logic [7:0] rd_data_o;
  logic done_o, err_o, tout_o, scl_low_o, sda_low_o;
  logic sl_drv = 1'b0;
  logic scl_bus, sda_bus;

  assign scl_bus = !scl_low_o;
  assign sda_bus = !(sda_low_o || sl_drv);

  eerd_master #(.DIV_W(DIV_W), .LEN_W(LEN_W), .RETRY_W(RETRY_W)) dut (
    .clk(clk), .rst_n(rst_n), .div_i(div_i), .poll_max_i(poll_max_i),
    .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
    .cmd_mode_i(cmd_mode_i), .cmd_dev_i(cmd_dev_i), .cmd_addr_i(cmd_addr_i),
    .cmd_len_i(cmd_len_i), .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i),
    .rd_data_o(rd_data_o), .done_o(done_o), .err_o(err_o), .tout_o(tout_o),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .sda_i(sda_bus)
  );

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [7:0] a);
    return (a * 8'd37 + 8'd91) ^ 8'h5A;
  endfunction

  // ---------------- EEPROM bus model ----------------
  int cfg_busy_until = 0;
  bit cfg_nack_addr = 0;
  int n_start = 0, n_stop = 0, n_mack = 0, n_mnack = 0, n_sel = 0;
  int n_busy_nack = 0, n_wbad = 0, n_w = 0, cyc = 0, rise_t = 0;
  logic [7:0] sel_log [8];
  logic [7:0] last_addr = 8'h00;
  logic [7:0] sl_ptr = 8'h00;
  logic [7:0] sl_shift = 8'h00, sl_cur = 8'h00;
  int sl_sm = 0, sl_cnt = 0, sl_nxt = 0;
  bit sl_isdev = 0, in_xfer = 0, meas_on = 0, sl_mack = 0;
  logic ps = 1'b1, pd = 1'b1;

  always @(negedge clk) begin
    logic s, d;
    s = scl_bus;
    d = sda_bus;
    cyc++;
    if (ps && s && pd && !d) begin
      n_start++; sl_sm = 1; sl_cnt = 0; sl_isdev = 1; sl_shift = 0; sl_drv = 0;
      in_xfer = 1; meas_on = 0;
    end else if (ps && s && !pd && d) begin
      n_stop++; sl_sm = 0; sl_drv = 0; in_xfer = 0; meas_on = 0;
    end else if (!ps && s) begin
      rise_t = cyc; meas_on = in_xfer;
      if (sl_sm == 1) begin sl_shift = {sl_shift[6:0], d}; sl_cnt++; end
      else if (sl_sm == 4) sl_mack = !d;
    end else if (ps && !s) begin
      if (meas_on) begin
        n_w++;
        if (cyc - rise_t != 2 * (int'(div_i) + 1)) n_wbad++;
        meas_on = 0;
      end
      case (sl_sm)
        1: if (sl_cnt == 8) begin
          if (sl_isdev) begin
            sel_log[n_sel % 8] = sl_shift;
            n_sel++;
            if (sl_shift[7:1] != DEVID) sl_sm = 0;
            else if (n_busy_nack < cfg_busy_until) begin n_busy_nack++; sl_sm = 0; end
            else begin sl_drv = 1; sl_sm = 2; sl_nxt = sl_shift[0] ? 1 : 2; end
          end else begin
            last_addr = sl_shift;
            if (cfg_nack_addr) sl_sm = 0;
            else begin sl_ptr = sl_shift; sl_drv = 1; sl_sm = 2; sl_nxt = 0; end
          end
        end
        2: begin
          sl_drv = 0;
          if (sl_nxt == 1) begin
            sl_cur = mem_byte(sl_ptr); sl_ptr++; sl_drv = !sl_cur[7]; sl_cnt = 1; sl_sm = 3;
          end else if (sl_nxt == 2) begin
            sl_sm = 1; sl_cnt = 0; sl_isdev = 0; sl_shift = 0;
          end else sl_sm = 0;
        end
        3: if (sl_cnt == 8) begin sl_drv = 0; sl_sm = 4; end
           else begin sl_drv = !sl_cur[7 - sl_cnt]; sl_cnt++; end
        4: begin
          if (sl_mack) begin
            n_mack++;
            sl_cur = mem_byte(sl_ptr); sl_ptr++; sl_drv = !sl_cur[7]; sl_cnt = 1; sl_sm = 3;
          end else begin n_mnack++; sl_sm = 0; end
        end
        default: ;
      endcase
    end
    ps = s; pd = d;
  end

  // ---------------- stream sink and monitors ----------------
  int ready_mode = 0;
  initial begin
    rd_ready_i = 1'b1;
    forever begin
      @(posedge clk); #1;
      rd_ready_i = (ready_mode == 0) ? 1'b1 : ($urandom % 4 == 0);
    end
  end

  logic [7:0] got [32];
  int got_n = 0, n_done = 0, n_holdbad = 0;
  bit last_err = 0, last_tout = 0, prev_stall = 0;
  logic [7:0] prev_data = 8'h00;
  always @(negedge clk) begin
    if (prev_stall && (!rd_valid_o || rd_data_o != prev_data || !scl_low_o)) n_holdbad++;
    prev_stall = rd_valid_o && !rd_ready_i;
    prev_data  = rd_data_o;
    if (rd_valid_o && rd_ready_i) begin got[got_n % 32] = rd_data_o; got_n++; end
    if (done_o) begin n_done++; last_err = err_o; last_tout = tout_o; end
  end

  // ---------------- command driver ----------------
  logic [7:0] exp_ptr = 8'h00;

  task automatic run_cmd(input int mode, input logic [6:0] dev, input logic [7:0] addr,
                         input int len, input int dv, input int pmax, input int busy,
                         input bit nack_addr, input int rmode);
    int b_start, b_stop, b_mack, b_mnack, b_sel, b_got, b_done, b_wbad, b_hold;
    int e_starts, wait_c;
    bit e_ok, e_err, e_tout, devok;
    logic [7:0] e_base;
    b_start = n_start; b_stop = n_stop; b_mack = n_mack; b_mnack = n_mnack;
    b_sel = n_sel; b_got = got_n; b_done = n_done; b_wbad = n_wbad; b_hold = n_holdbad;
    div_i = dv[DIV_W-1:0]; poll_max_i = pmax[RETRY_W-1:0];
    cfg_busy_until = n_busy_nack + busy; cfg_nack_addr = nack_addr; ready_mode = rmode;
    cmd_mode_i = mode[1:0]; cmd_dev_i = dev; cmd_addr_i = addr; cmd_len_i = len[LEN_W-1:0];
    cmd_valid_i = 1'b1;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    wait_c = 0;
    while (n_done == b_done && wait_c < 20000) begin @(negedge clk); wait_c++; end
    repeat (3) @(negedge clk);
    cfg_busy_until = n_busy_nack; cfg_nack_addr = 0;
    devok = (dev == DEVID);
    e_ok = 0; e_err = 0; e_tout = 0;
    if (mode == 0) begin
      e_starts = 1; if (devok) e_ok = 1; else e_err = 1;
    end else if (mode == 1) begin
      if (devok && busy == 0 && !nack_addr) begin e_ok = 1; e_starts = 2; end
      else begin e_err = 1; e_starts = 1; end
    end else begin
      if (!devok || busy > pmax) begin e_tout = 1; e_starts = pmax + 1; end
      else if (nack_addr) begin e_err = 1; e_starts = busy + 1; end
      else begin e_ok = 1; e_starts = busy + 2; end
    end
    e_base = (mode == 0) ? exp_ptr : addr;
    chk(n_done - b_done == 1, "R10 one done pulse", n_done - b_done, 1);
    chk(last_err == e_err, "R9 err flag", last_err, e_err);
    chk(last_tout == e_tout, "R8 timeout flag", last_tout, e_tout);
    chk(n_start - b_start == e_starts, mode >= 2 ? "R7 START count" : "R4 START count",
        n_start - b_start, e_starts);
    chk(n_sel - b_sel == e_starts, "R7 select attempts", n_sel - b_sel, e_starts);
    chk(n_stop - b_stop == 1, "R5 single STOP", n_stop - b_stop, 1);
    chk(got_n - b_got == (e_ok ? len + 1 : 0), "R5 byte count", got_n - b_got, e_ok ? len + 1 : 0);
    chk(n_wbad == b_wbad, "R2 SCL high width", n_wbad - b_wbad, 0);
    chk(n_holdbad == b_hold, "R6 stall hold", n_holdbad - b_hold, 0);
    if (e_ok) begin
      for (int k = 0; k <= len; k++) begin
        logic [7:0] ev;
        ev = mem_byte(e_base + k[7:0]);
        chk(got[(b_got + k) % 32] == ev, mode == 0 ? "R3 data byte" : "R4 data byte",
            got[(b_got + k) % 32], ev);
      end
      chk(n_mack - b_mack == len, "R5 master ACK count", n_mack - b_mack, len);
      chk(n_mnack - b_mnack == 1, "R5 final NACK", n_mnack - b_mnack, 1);
      chk(sel_log[(n_sel - 1) % 8] == {dev, 1'b1}, "R3 read select byte",
          sel_log[(n_sel - 1) % 8], {dev, 1'b1});
      if (mode != 0) begin
        chk(sel_log[(n_sel - 2) % 8] == {dev, 1'b0}, "R4 write select byte",
            sel_log[(n_sel - 2) % 8], {dev, 1'b0});
        chk(last_addr == addr, "R4 address byte", last_addr, addr);
      end
      exp_ptr = e_base + 8'(len + 1);
    end
    chk(cmd_ready_o && !rd_valid_o && !scl_low_o && !sda_low_o, "R1 idle after command",
        {cmd_ready_o, rd_valid_o, scl_low_o, sda_low_o}, 4'b1000);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    void'($urandom(32'h1D5E7));
    rst_n = 1'b0; cmd_valid_i = 1'b0; cmd_mode_i = 2'd0; cmd_dev_i = DEVID;
    cmd_addr_i = 8'h00; cmd_len_i = '0; div_i = 8'd1; poll_max_i = '0;
    repeat (4) @(negedge clk);
    chk(!scl_low_o && !sda_low_o, "R1 lines released in reset", {scl_low_o, sda_low_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cmd_ready_o == 1'b1, "R1 ready after reset", cmd_ready_o, 1);
    chk(rd_valid_o == 1'b0, "R1 no data after reset", rd_valid_o, 0);

    run_cmd(0, DEVID, 8'h00, 0, 1, 0, 0, 0, 0);   // R3 current read at 0
    run_cmd(1, DEVID, 8'hFE, 3, 2, 0, 0, 0, 1);   // R4 R5 wrap, stalled stream R6
    run_cmd(0, DEVID, 8'h00, 2, 0, 0, 0, 0, 1);   // R3 continues after wrap
    run_cmd(2, DEVID, 8'h40, 1, 1, 3, 3, 0, 0);   // R7 succeeds on last retry
    run_cmd(2, DEVID, 8'h41, 0, 1, 2, 3, 0, 0);   // R8 one poll short
    run_cmd(3, DEVID, 8'h42, 0, 3, 0, 0, 0, 0);   // R7 no busy, poll code 3
    run_cmd(1, DEVID, 8'h43, 0, 1, 0, 1, 0, 0);   // R9 busy without polling
    run_cmd(1, DEVID, 8'h44, 0, 1, 0, 0, 1, 0);   // R9 address NACK
    run_cmd(0, DEVID ^ 7'h01, 8'h00, 0, 1, 0, 0, 0, 0); // R9 wrong device
    run_cmd(2, DEVID ^ 7'h02, 8'h00, 0, 0, 1, 0, 0, 0); // R8 wrong device polled
    run_cmd(0, DEVID, 8'h00, 0, 2, 0, 0, 0, 0);   // R3 pointer unchanged by failures

    for (int i = 0; i < 22; i++) begin
      int m, ln, dv, pm, bz;
      bit na;
      logic [6:0] dv_code;
      m  = $urandom % 4;
      ln = $urandom % 5;
      dv = $urandom % 4;
      pm = $urandom % 4;
      bz = (m == 0) ? 0 : $urandom % 4;
      na = (m != 0) && ($urandom % 8 == 0);
      dv_code = ($urandom % 8 == 0) ? (DEVID ^ 7'h04) : DEVID;
      run_cmd(m, dv_code, 8'($urandom), ln, dv, pm, bz, na, $urandom % 2);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule